// File: doc/BRIEF.md
# Global Configuration and Interrupt Vector Unit

This block holds the chip-wide configuration byte of a multi-channel serial controller's host interface and forms the byte placed on the data bus when the host acknowledges an interrupt. The host writes and reads it over a small bus: active-low chip enable, write strobe and read strobe, a register address and a byte of write data, all sampled on the system clock. Two registers live here. The configuration register is at address 0 and the vector base register is at address 1.

The configuration byte has several jobs. It chooses between long asynchronous host cycles and fixed four-clock synchronous cycles. It chooses how the acknowledge vector is built, and it gates the device into a low-power state. A reserved top bit, when set, shuts off addressing of the other registers. When the interrupt acknowledge input goes low, the block samples the channel number and source type offered by the interrupt arbiter. It builds the vector once and presents it until the acknowledge ends.

Top module: `gcfg_ivec_top`

## Requirements
- R1: After reset the configuration register reads 0x00, `addr_en` is 1, `sync_mode` is 0 and `pwr_down` is 0.
- R2: Configuration bits 5:3, 2:1 and 0 are stored on a write to address 0 and read back as written. Bits 5:3 have no effect on any output.
- R3: Configuration bit 7 set to 1 drives `addr_en` to 0. While it is set, writes to the vector base register (address 1) are ignored and reads of it return 0x00. The configuration register stays accessible.
- R4: Vector control (configuration bits 2:1) of 00 makes the acknowledge vector 0xFF.
- R5: Vector control 01 presents the vector base unchanged.
- R6: Vector control 10 presents vector base bits 7:3 with the 3-bit channel number in bits 2:0.
- R7: Vector control 11 presents vector base bits 7:5, the 2-bit source type in bits 4:3 and the channel number in bits 2:0. The type is passed through as given: 10 means a receiver without error, 11 a receiver with error, 01 a transmitter and 00 any other source.
- R8: `pwr_down` equals configuration bit 0 from the clock after the write.
- R9: Writing bit 6 as 1 does not switch modes while chip enable stays low. `sync_mode` rises on the first clock at which chip enable is sampled high afterwards, and bit 6 then reads back as 1.
- R10: For the two clocks after `sync_mode` rises, every host access is ignored.
- R11: Once set, `sync_mode` stays 1 until reset. A later write of bit 6 as 0 leaves it at 1.
- R12: The vector is built on the first clock at which `iack_n` is sampled low. It is output from that clock until `iack_n` is high. Later changes of channel, type or configuration do not alter it.
- R13: While a vector is output it takes priority on `dout` over a register read. With neither a vector nor a read active, `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| dout | output | 8 | Read data or acknowledge vector |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| irq_chan | input | 3 | Winning channel number from the arbiter |
| irq_type | input | 2 | Source type of the winning interrupt |
| addr_en | output | 1 | Register addressing enabled |
| sync_mode | output | 1 | Synchronous host cycles in force |
| pwr_down | output | 1 | Gates off channel activity when 1 |

## Verification
A configuration write and the start of an acknowledge can land on the same clock edge. The bench provokes this by opening an acknowledge in the very cycle that a write changes the vector control field. The vector must still be built from the old field, and a readback afterwards must show the new field. A register read held active during an acknowledge is also checked, and only the vector may reach `dout`.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;

  localparam int DATA_W = 8;
  localparam int CHAN_W = 3;
  localparam int TYPE_W = 2;

  typedef enum logic [1:0] {
    VC_NONE = 2'b00,
    VC_BASE = 2'b01,
    VC_CHAN = 2'b10,
    VC_FULL = 2'b11
  } vc_e;

  // bit positions fixed: host software decodes this byte
  typedef struct packed {
    logic       rsv_hi;   // 7: disables addressing when set
    logic       sync;     // 6: synchronous host cycles
    logic [2:0] rsv_mid;  // 5:3: stored only
    vc_e        vc;       // 2:1: vector control
    logic       pdn;      // 0: power down
  } cfg_t;

  function automatic logic [DATA_W-1:0] build_vec(
    input vc_e               vc,
    input logic [DATA_W-1:0] base,
    input logic [CHAN_W-1:0] chan,
    input logic [TYPE_W-1:0] typ
  );
    logic [DATA_W-1:0] v;
    case (vc)
      VC_NONE: v = '1;
      VC_BASE: v = base;
      VC_CHAN: v = {base[DATA_W-1:CHAN_W], chan};
      default: v = {base[DATA_W-1:CHAN_W+TYPE_W], typ, chan};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gcfg_regs.sv
module gcfg_regs
  import gcfg_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          GAP_CYC = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0,
  parameter logic [ADDR_W-1:0] VB_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] vbase,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_cfg
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);

  cfg_t              cfg_q, cfg_d;
  logic [DATA_W-1:0] vb_q, vb_d;
  logic              pend_q, pend_d;
  logic [GAP_W-1:0]  gap_q, gap_d;

  logic bus_open, sel, wr_vb, rd_cfg, rd_vb, commit;

  always_comb begin
    bus_open = (gap_q == '0);
    sel      = !cs_n && bus_open;
    wr_cfg   = sel && !wr_n && (addr == CFG_ADDR);
    wr_vb    = sel && !wr_n && (addr == VB_ADDR) && !cfg_q.rsv_hi;
    rd_cfg   = sel && !rd_n && (addr == CFG_ADDR);
    rd_vb    = sel && !rd_n && (addr == VB_ADDR) && !cfg_q.rsv_hi;
    commit   = pend_q && cs_n && !cfg_q.sync;
  end

  always_comb begin
    cfg_d  = cfg_q;
    vb_d   = vb_q;
    pend_d = pend_q;
    gap_d  = gap_q - GAP_W'(gap_q != '0);
    if (wr_cfg) begin
      cfg_d      = cfg_t'(wdata);
      cfg_d.sync = cfg_q.sync;
      if (!cfg_q.sync) pend_d = wdata[6];
    end
    if (wr_vb) vb_d = wdata;
    if (commit) begin
      cfg_d.sync = 1'b1;
      pend_d     = 1'b0;
      gap_d      = GAP_W'(GAP_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      vb_q   <= '0;
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      vb_q   <= vb_d;
      pend_q <= pend_d;
      gap_q  <= gap_d;
    end
  end

  always_comb begin
    if (rd_cfg)     rdata = cfg_q;
    else if (rd_vb) rdata = vb_q;
    else            rdata = '0;
  end

  assign cfg   = cfg_q;
  assign vbase = vb_q;

endmodule

// File: rtl/gcfg_ivec.sv
module gcfg_ivec
  import gcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_n,
  input  logic [CHAN_W-1:0] chan,
  input  logic [TYPE_W-1:0] typ,
  input  vc_e               vc,
  input  logic [DATA_W-1:0] vbase,
  output logic [DATA_W-1:0] vec,
  output logic              vec_vld
);

  logic              ack_q, ack_d;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic              start;

  always_comb begin
    start = !iack_n && !ack_q;
    ack_d = !iack_n;
    vec_d = start ? build_vec(vc, vbase, chan, typ) : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_d;
      vec_q <= vec_d;
    end
  end

  assign vec     = vec_q;
  assign vec_vld = ack_q && !iack_n;

endmodule

// File: rtl/gcfg_ivec_top.sv
module gcfg_ivec_top
  import gcfg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int GAP_CYC     = 2,
  parameter int RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0,
  parameter logic [ADDR_W-1:0] VB_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        dout,
  input  logic              iack_n,
  input  logic [2:0]        irq_chan,
  input  logic [1:0]        irq_type,
  output logic              addr_en,
  output logic              sync_mode,
  output logic              pwr_down
);

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i = rs_q[RST_STAGES-1];

  cfg_t              cfg;
  logic [DATA_W-1:0] vbase, rdata, vec;
  logic              vec_vld, wr_cfg;
  logic [1:0]        cfg_vc;

  gcfg_regs #(
    .ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC), .CFG_ADDR(CFG_ADDR), .VB_ADDR(VB_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .wdata(wdata), .cfg(cfg), .vbase(vbase), .rdata(rdata),
    .wr_cfg(wr_cfg)
  );

  gcfg_ivec u_ivec (
    .clk(clk), .rst_n(rst_i), .iack_n(iack_n), .chan(irq_chan), .typ(irq_type),
    .vc(cfg.vc), .vbase(vbase), .vec(vec), .vec_vld(vec_vld)
  );

  assign cfg_vc    = cfg.vc;
  assign dout      = vec_vld ? vec : rdata;
  assign addr_en   = !cfg.rsv_hi;
  assign sync_mode = cfg.sync;
  assign pwr_down  = cfg.pdn;

endmodule

// File: rtl/gcfg_chk.sv
module gcfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       iack_n,
  input logic [7:0] wdata,
  input logic [7:0] dout,
  input logic       addr_en,
  input logic       pwr_down,
  input logic       sync_mode,
  input logic       wr_cfg,
  input logic       vec_vld,
  input logic [1:0] vc
);

  AST_ADDR_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (addr_en == !$past(wdata[7]))); // R3

  AST_PDN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (pwr_down == $past(wdata[0]))); // R8

  AST_SYNC_ON_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> $past(cs_n)); // R9

  AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_mode) |-> !wr_cfg); // R10

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> sync_mode); // R11

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && !vec_vld && vc == 2'b00) |=> (iack_n || dout == 8'hFF)); // R4

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld && $past(vec_vld)) |-> $stable(dout)); // R12

endmodule

bind gcfg_ivec_top gcfg_chk u_chk (
  .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .iack_n(iack_n), .wdata(wdata),
  .dout(dout), .addr_en(addr_en), .pwr_down(pwr_down), .sync_mode(sync_mode),
  .wr_cfg(wr_cfg), .vec_vld(vec_vld), .vc(cfg_vc)
);

// File: tb/tb_gcfg_ivec_top.sv
`timescale 1ns/1ps
module tb_gcfg_ivec_top;

  localparam int AW = 4;
  localparam logic [AW-1:0] A_CFG = 4'd0;
  localparam logic [AW-1:0] A_VB  = 4'd1;

  logic clk = 1'b0;
  logic rst_n, cs_n, wr_n, rd_n, iack_n;
  logic [AW-1:0] addr;
  logic [7:0] wdata, dout;
  logic [2:0] irq_chan;
  logic [1:0] irq_type;
  logic addr_en, sync_mode, pwr_down;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gcfg_ivec_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .wdata(wdata), .dout(dout), .iack_n(iack_n),
    .irq_chan(irq_chan), .irq_type(irq_type), .addr_en(addr_en),
    .sync_mode(sync_mode), .pwr_down(pwr_down)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    tick();
    cs_n = 1; wr_n = 1;
    tick();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    cs_n = 0; rd_n = 0; addr = a;
    #1 v = dout;
    cs_n = 1; rd_n = 1;
    #1;
  endtask

  function automatic logic [7:0] exp_vec(input int vc, input logic [7:0] b,
                                         input int ch, input int ty);
    case (vc)
      0: return 8'hFF;
      1: return b;
      2: return (b & 8'hF8) | 8'(ch);
      default: return (b & 8'hE0) | 8'(ty * 8) | 8'(ch);
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 0; cs_n = 1; wr_n = 1; rd_n = 1; iack_n = 1;
    addr = '0; wdata = '0; irq_chan = '0; irq_type = '0;
    tick(); tick();
    rst_n = 1;
    tick(); tick(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] bases [4];
    bases[0] = 8'h00; bases[1] = 8'hA5; bases[2] = 8'h5A; bases[3] = 8'hFF;

    do_reset();
    // R1 reset state
    rd(A_CFG, v);
    chk("R1 cfg", v, 8'h00);
    chk("R1 addr_en", {7'd0, addr_en}, 8'd1);
    chk("R1 sync", {7'd0, sync_mode}, 8'd0);
    chk("R1 pdn", {7'd0, pwr_down}, 8'd0);
    chk("R13 idle dout", dout, 8'h00);

    // R2, R3, R8: sweep all values with bit 6 clear
    for (int i = 0; i < 256; i++) begin
      if (i[6]) continue;
      wr(A_CFG, 8'(i));
      rd(A_CFG, v);
      chk("R2 readback", v, 8'(i));
      chk("R3 addr_en", {7'd0, addr_en}, {7'd0, ~i[7]});
      chk("R8 pdn", {7'd0, pwr_down}, {7'd0, i[0]});
    end

    // R3: vector base locked while bit 7 set
    wr(A_CFG, 8'h00);
    wr(A_VB, 8'h3C);
    rd(A_VB, v); chk("R3 vb open", v, 8'h3C);
    wr(A_CFG, 8'h80);
    wr(A_VB, 8'hC3);
    rd(A_VB, v); chk("R3 vb read blocked", v, 8'h00);
    rd(A_CFG, v); chk("R3 cfg reachable", v, 8'h80);
    wr(A_CFG, 8'h00);
    rd(A_VB, v); chk("R3 vb write ignored", v, 8'h3C);

    // R4..R7, R12: vector sweep
    for (int vc = 0; vc < 4; vc++) begin
      for (int b = 0; b < 4; b++) begin
        wr(A_CFG, 8'(vc * 2));
        wr(A_VB, bases[b]);
        for (int ch = 0; ch < 8; ch++) begin
          for (int ty = 0; ty < 4; ty++) begin
            irq_chan = 3'(ch); irq_type = 2'(ty);
            iack_n = 0;
            tick();
            chk(vc == 0 ? "R4 vector" : vc == 1 ? "R5 vector" :
                vc == 2 ? "R6 vector" : "R7 vector",
                dout, exp_vec(vc, bases[b], ch, ty));
            irq_chan = ~irq_chan; irq_type = ~irq_type;
            tick();
            chk("R12 vector held", dout, exp_vec(vc, bases[b], ch, ty));
            iack_n = 1;
            tick();
          end
        end
      end
    end

    // R12/R13: write landing on the capture edge, read during ack
    wr(A_CFG, 8'h06);
    wr(A_VB, 8'h88);
    irq_chan = 3'd5; irq_type = 2'b11;
    iack_n = 0; cs_n = 0; wr_n = 0; addr = A_CFG; wdata = 8'h02;
    tick();
    cs_n = 1; wr_n = 1;
    chk("R12 old vc used", dout, 8'h9D);
    cs_n = 0; rd_n = 0; addr = A_CFG;
    #1 chk("R13 vector wins", dout, 8'h9D);
    cs_n = 1; rd_n = 1;
    tick();
    chk("R12 held after write", dout, 8'h9D);
    iack_n = 1;
    tick();
    rd(A_CFG, v); chk("R12 new vc stored", v, 8'h02);

    // R9, R10, R11: synchronous mode commit
    cs_n = 0; wr_n = 0; addr = A_CFG; wdata = 8'h40;
    tick(); tick();
    chk("R9 no switch while cs low", {7'd0, sync_mode}, 8'd0);
    cs_n = 1; wr_n = 1;
    tick();
    chk("R9 switch on cs high", {7'd0, sync_mode}, 8'd1);
    cs_n = 0; wr_n = 0; addr = A_CFG; wdata = 8'h01;
    tick();
    chk("R10 gap clk1", {7'd0, pwr_down}, 8'd0);
    tick();
    chk("R10 gap clk2", {7'd0, pwr_down}, 8'd0);
    tick();
    chk("R10 after gap", {7'd0, pwr_down}, 8'd1);
    cs_n = 1; wr_n = 1;
    tick();
    chk("R11 sticky", {7'd0, sync_mode}, 8'd1);
    rd(A_CFG, v); chk("R9 bit6 reads 1", v, 8'h41);

    do_reset();
    chk("R11 reset clears", {7'd0, sync_mode}, 8'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule